// File: doc/BRIEF.md
# Gray-Coded Pointer Counter with Registered Status Flag

This block is one side of a dual-clock queue's pointer logic. It lives entirely in one clock domain. It keeps a binary count and a Gray-coded copy of that count. The low bits of the binary count address the storage array, and the Gray copy is the value that crosses into the other clock domain. The block also takes in the other side's Gray pointer, already synchronized, and registers a status flag from it.

A parameter selects the role of the unit. In read role the flag means "empty". In write role it means "full". The flag is computed from the Gray value that is about to be loaded, so the flag and the pointer change on the same clock edge. While the flag is set, increment requests are refused. The synchronizers and the storage array sit outside this block.

Top module: `gptr_unit`

## Requirements
- R1: While `rst_n` is low, `gray_ptr` and `addr` are 0 and `inc` has no effect. `flag` is 1 in read role and 0 in write role.
- R2: On a rising edge where `inc` is 1 and `flag` is 0, the internal binary count increases by one, modulo 2^PTR_W. `addr` always equals bits [PTR_W-2:0] of that count.
- R3: On a rising edge where `inc` is 0 or `flag` is 1, `gray_ptr` and `addr` keep their values.
- R4: `gray_ptr` equals the count XOR (count shifted right by one), so its top bit equals the top bit of the count.
- R5: Whenever `gray_ptr` changes, the new value differs from the previous one in exactly one bit. This includes the step from 2^PTR_W-1 back to 0.
- R6: In read role, `flag` after an edge is 1 exactly when the `gray_ptr` loaded at that edge equals, in every bit, the `peer_ptr` sampled at that edge.
- R7: In write role, `flag` after an edge is 1 exactly when the `gray_ptr` loaded at that edge and the `peer_ptr` sampled at that edge differ in both of their two most significant bits and match in all lower bits.
- R8: After 2^PTR_W accepted increments, the pointer returns to 0. `addr` repeats with period 2^(PTR_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of this pointer's domain |
| rst_n | input | 1 | Active-low reset, sampled on `clk` |
| inc | input | 1 | Request to advance the pointer by one |
| peer_ptr | input | PTR_W | Opposite side's Gray pointer, already synchronized |
| addr | output | PTR_W-1 | Storage array address (low bits of the binary count) |
| gray_ptr | output | PTR_W | Registered Gray-coded pointer |
| flag | output | 1 | Registered empty (read role) or full (write role) |

## Verification
The bound checker covers the relations that must hold on every cycle:
- a refused or absent increment leaves the pointer and address unchanged;
- an accepted increment moves the address by one;
- every pointer change flips exactly one bit;
- decoding the Gray pointer gives back the address bits;
- the flag after each edge matches the role's comparison between the freshly loaded pointer and the peer value sampled at that edge.

Some behaviour only the bench scenarios can show: the reset values, that increments are blocked once empty or full is reached, that full clears when the peer moves on, and that a full walk through every code wraps cleanly back to zero.

// File: rtl/gptr_pkg.sv
package gptr_pkg;

   typedef enum logic {
      GPTR_RD = 1'b0,
      GPTR_WR = 1'b1
   } gptr_mode_e;

   // Flag value held during reset: empty is asserted for a reader,
   // full is deasserted for a writer.
   function automatic logic gptr_reset_flag(gptr_mode_e mode);
      return (mode == GPTR_RD);
   endfunction

endpackage

// File: rtl/gptr_bin_reg.sv
module gptr_bin_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] bin_d,
   output logic [W-1:0] bin_q
);

   assign bin_d = bin_q + W'(step);

   always_ff @(posedge clk) begin
      if (!rst_n) bin_q <= '0;
      else        bin_q <= bin_d;
   end

endmodule

// File: rtl/gptr_gray_reg.sv
module gptr_gray_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] bin_d,
   output logic [W-1:0] gray_d,
   output logic [W-1:0] gray_q
);

   // Each lower bit is the XOR of a binary bit and its upper neighbour;
   // the top bit passes through unchanged.
   for (genvar i = 0; i < W - 1; i++) begin : g_bit
      assign gray_d[i] = bin_d[i+1] ^ bin_d[i];
   end
   assign gray_d[W-1] = bin_d[W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) gray_q <= '0;
      else        gray_q <= gray_d;
   end

endmodule

// File: rtl/gptr_flag_gen.sv
module gptr_flag_gen
   import gptr_pkg::*;
#(
   parameter int         W    = 4,
   parameter gptr_mode_e MODE = GPTR_RD
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_d,
   input  logic [W-1:0] peer,
   output logic         flag_q
);

   localparam logic RST_VAL = gptr_reset_flag(MODE);

   logic hit;

   if (MODE == GPTR_RD) begin : g_empty
      assign hit = (gray_d == peer);
   end else begin : g_full
      assign hit = (gray_d == {~peer[W-1:W-2], peer[W-3:0]});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= RST_VAL;
      else        flag_q <= hit;
   end

endmodule

// File: rtl/gptr_unit.sv
module gptr_unit
   import gptr_pkg::*;
#(
   parameter int         PTR_W = 4,
   parameter gptr_mode_e MODE  = GPTR_RD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic [PTR_W-1:0]   peer_ptr,
   output logic [PTR_W-2:0]   addr,
   output logic [PTR_W-1:0]   gray_ptr,
   output logic               flag
);

   localparam int ADDR_W = PTR_W - 1;

   if (PTR_W < 3) begin : g_bad_width
      $error("gptr_unit: PTR_W must be at least 3");
   end

   logic               step;
   logic [PTR_W-1:0]   bin_d;
   logic [PTR_W-1:0]   bin_q;
   logic [PTR_W-1:0]   gray_d;

   assign step = inc & ~flag;

   gptr_bin_reg #(.W(PTR_W)) u_bin (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .bin_d (bin_d),
      .bin_q (bin_q)
   );

   gptr_gray_reg #(.W(PTR_W)) u_gray (
      .clk    (clk),
      .rst_n  (rst_n),
      .bin_d  (bin_d),
      .gray_d (gray_d),
      .gray_q (gray_ptr)
   );

   gptr_flag_gen #(.W(PTR_W), .MODE(MODE)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .gray_d (gray_d),
      .peer   (peer_ptr),
      .flag_q (flag)
   );

   assign addr = bin_q[ADDR_W-1:0];

endmodule

// File: rtl/gptr_unit_chk.sv
module gptr_unit_chk
   import gptr_pkg::*;
#(
   parameter int         PTR_W = 4,
   parameter gptr_mode_e MODE  = GPTR_RD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic [PTR_W-1:0]   peer_ptr,
   input  logic [PTR_W-2:0]   addr,
   input  logic [PTR_W-1:0]   gray_ptr,
   input  logic               flag
);

   localparam int ADDR_W = PTR_W - 1;

   // Decode the Gray output back to binary, independently of the RTL path.
   logic [PTR_W-1:0] dec_bin;
   for (genvar i = 0; i < PTR_W; i++) begin : g_dec
      assign dec_bin[i] = ^gray_ptr[PTR_W-1:i];
   end

   // R3
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc || flag) |=> ($stable(gray_ptr) && $stable(addr)));

   // R2
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !flag) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

   // R4
   p_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_bin[ADDR_W-1:0] == addr);

   // R5
   p_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gray_ptr != $past(gray_ptr)) |-> ($countones(gray_ptr ^ $past(gray_ptr)) == 1));

   if (MODE == GPTR_RD) begin : g_rd
      // R6
      p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (flag == (gray_ptr == $past(peer_ptr))));
   end else begin : g_wr
      // R7
      p_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (flag == ((gray_ptr[PTR_W-1] != $past(peer_ptr[PTR_W-1])) &&
                            (gray_ptr[PTR_W-2] != $past(peer_ptr[PTR_W-2])) &&
                            (gray_ptr[PTR_W-3:0] == $past(peer_ptr[PTR_W-3:0])))));
   end

endmodule

bind gptr_unit gptr_unit_chk #(.PTR_W(PTR_W), .MODE(MODE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .inc      (inc),
   .peer_ptr (peer_ptr),
   .addr     (addr),
   .gray_ptr (gray_ptr),
   .flag     (flag)
);

// File: tb/gptr_unit_test.sv
module gptr_unit_test;
   import gptr_pkg::*;

   localparam int N     = 4;
   localparam int DEPTH = 1 << N;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         inc_r = 1'b0, inc_w = 1'b0;
   logic [N-1:0] peer_r = '0, peer_w = '0;
   logic [N-2:0] addr_r, addr_w;
   logic [N-1:0] gray_r, gray_w;
   logic         flag_r, flag_w;

   int n_chk = 0;
   int n_bad = 0;
   int cnt_r = 0, cnt_w = 0;
   bit fm_r = 1'b1, fm_w = 1'b0;

   always #2 clk = ~clk;

   gptr_unit #(.PTR_W(N), .MODE(GPTR_RD)) uut (
      .clk(clk), .rst_n(rst_n), .inc(inc_r), .peer_ptr(peer_r),
      .addr(addr_r), .gray_ptr(gray_r), .flag(flag_r));

   gptr_unit #(.PTR_W(N), .MODE(GPTR_WR)) uut_wr (
      .clk(clk), .rst_n(rst_n), .inc(inc_w), .peer_ptr(peer_w),
      .addr(addr_w), .gray_ptr(gray_w), .flag(flag_w));

   function automatic logic [N-1:0] g(int x);
      logic [N-1:0] b;
      b = N'(x);
      return b ^ (b >> 1);
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk(req, "rd addr", int'(addr_r), cnt_r % (DEPTH / 2));
      chk(req, "rd gray", int'(gray_r), int'(g(cnt_r)));
      chk(req, "rd flag", int'(flag_r), int'(fm_r));
      chk(req, "wr addr", int'(addr_w), cnt_w % (DEPTH / 2));
      chk(req, "wr gray", int'(gray_w), int'(g(cnt_w)));
      chk(req, "wr flag", int'(flag_w), int'(fm_w));
   endtask

   // Called at a falling edge: drive inputs, update model, check at next falling edge.
   task automatic tick(logic ir, logic [N-1:0] pr, logic iw, logic [N-1:0] pw, string req);
      inc_r = ir; peer_r = pr; inc_w = iw; peer_w = pw;
      if (ir && !fm_r) cnt_r = (cnt_r + 1) % DEPTH;
      fm_r = (g(cnt_r) == pr);
      if (iw && !fm_w) cnt_w = (cnt_w + 1) % DEPTH;
      fm_w = (g(cnt_w) == {~pw[N-1:N-2], pw[N-3:0]});
      @(negedge clk);
      check_all(req);
   endtask

   task automatic t_reset();
      inc_r = 1'b1; inc_w = 1'b1; peer_r = 4'd5; peer_w = 4'd9;
      repeat (3) @(negedge clk);
      check_all("R1");
      inc_r = 1'b0; inc_w = 1'b0;
      rst_n = 1'b1;
      check_all("R1");
   endtask

   task automatic t_read_empty();
      tick(1'b0, g(3), 1'b0, '0, "R6");        // empty clears, nothing moves
      for (int i = 0; i < 3; i++) tick(1'b1, g(3), 1'b0, '0, "R6");
      chk("R6", "rd empty at count 3", int'(flag_r), 1);
      for (int i = 0; i < 2; i++) tick(1'b1, g(3), 1'b0, '0, "R3");
      chk("R3", "rd held at 3", int'(gray_r), int'(g(3)));
   endtask

   task automatic t_write_full();
      for (int i = 0; i < DEPTH / 2; i++) tick(1'b0, g(cnt_r + 7), 1'b1, g(0), "R7");
      chk("R7", "wr full at depth", int'(flag_w), 1);
      for (int i = 0; i < 2; i++) tick(1'b0, g(cnt_r + 7), 1'b1, g(0), "R3");
      chk("R3", "wr held at depth", int'(gray_w), int'(g(DEPTH / 2)));
      tick(1'b0, g(cnt_r + 7), 1'b0, g(1), "R7");
      chk("R7", "wr full clears", int'(flag_w), 0);
      tick(1'b0, g(cnt_r + 7), 1'b1, g(1), "R7");
      chk("R7", "wr full again", int'(flag_w), 1);
   endtask

   task automatic t_walk();
      logic [N-1:0] prev;
      int           start;
      start = cnt_r;
      tick(1'b0, g(cnt_r + 5), 1'b0, g(cnt_w + 3), "R2");  // release empty
      for (int i = 0; i < DEPTH; i++) begin
         prev = gray_r;
         tick(1'b1, g(cnt_r + 5), 1'b0, g(cnt_w + 3), "R2");
         chk("R5", "one bit change", $countones(gray_r ^ prev), 1);
         chk("R4", "top bit", int'(gray_r[N-1]), (cnt_r >> (N - 1)) & 1);
      end
      chk("R8", "wrapped to start", int'(gray_r), int'(g(start)));
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_read_empty();
      t_write_full();
      t_walk();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule